// File: doc/BRIEF.md
# I2C Slave Address Recognizer with General Call

This block is the addressing front end of an I2C slave. It watches the sampled SCL and SDA lines for start and stop conditions. After a start it shifts in the first byte MSB first and compares it with a programmable own address and with the fixed all-zero general-call address. When a byte is accepted, the block copies it into a one-byte receive buffer, pulls SDA low through the acknowledge clock and raises an interrupt. Once the slave is addressed, later bytes pass through the same buffer until the next start or stop.

Two addressing modes are supported. In 7-bit mode a single byte selects the slave. In 10-bit mode a header byte that carries the two upper address bits is acknowledged first and raises an update-address flag. A second byte that must equal the low eight address bits follows. A general call, honoured only while its enable is set, skips the second byte in either mode. Software reads the buffered byte to tell a general call from a directed address. It clears the buffer-full flag, the interrupt and the update-address flag with single-cycle strobes.

The SCL and SDA inputs must already be synchronised to `clk`. Every SCL level must last at least two clock cycles.

Top module: `i2c_slave_addr_rx`

## Requirements
- R1: After reset, `sda_low_o`, `buf_full_o`, `irq_o`, `upd_addr_o`, `start_flag_o` and `stop_flag_o` are all 0, and `rx_byte_o` is 0x00.
- R2: A start (SDA falls while SCL is high) sets `start_flag_o` and clears `stop_flag_o`. A stop (SDA rises while SCL is high) sets `stop_flag_o` and clears `start_flag_o`. After a stop, bytes clocked without a new start are not acknowledged and change no flag.
- R3: In 7-bit mode (`ten_bit_i`=0), a first byte whose bits 7:1 equal `own_addr_i[6:0]` is acknowledged. Acknowledging means SDA is held low through the whole high phase of the 9th clock. Any other first byte, except an enabled general call, is not acknowledged: SDA stays released, and the slave ignores the bus until the next start.
- R4: A first byte of 0x00 is accepted as a general call when `gc_en_i`=1, in either mode. It is not acknowledged when `gc_en_i`=0.
- R5: For every accepted byte, `rx_byte_o` takes the byte and `buf_full_o` rises at the 8th rising SCL edge, before the acknowledge clock starts.
- R6: `irq_o` rises at the falling SCL edge that ends the 9th clock of an accepted byte, not earlier. It stays high until an `irq_clr_i` pulse.
- R7: In 10-bit mode, a first byte of the form 1,1,1,1,0,`own_addr_i[9]`,`own_addr_i[8]`,0 (bit 7 down to bit 0) is acknowledged and sets `upd_addr_o`. An `addr_wr_i` pulse clears `upd_addr_o`. A header with bit 0 = 1 or with the wrong high bits is not acknowledged.
- R8: In 10-bit mode, the byte after an accepted header is acknowledged only if it equals `own_addr_i[7:0]`. On a match the slave moves to data reception and `upd_addr_o` is not set again.
- R9: In 10-bit mode, an accepted general call leaves `upd_addr_o` at 0, and the next byte is taken as data with no second address byte.
- R10: Data bytes after an accepted address are acknowledged and buffered while `buf_full_o` is 0. While `buf_full_o` is 1, a data byte is not acknowledged and `rx_byte_o` keeps its value. A `buf_rd_i` pulse clears `buf_full_o`.
- R11: `sda_low_o` changes only while SCL is low, so the slave never creates a start or stop of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| own_addr_i | input | 10 | Own slave address (7-bit mode uses bits 6:0) |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| gc_en_i | input | 1 | 1 enables general-call recognition |
| addr_wr_i | input | 1 | Pulse: address updated, clears the update-address flag |
| buf_rd_i | input | 1 | Pulse: buffer read, clears buffer-full |
| irq_clr_i | input | 1 | Pulse: clears the interrupt flag |
| sda_low_o | output | 1 | 1 pulls SDA low (acknowledge) |
| rx_byte_o | output | 8 | Last accepted byte |
| buf_full_o | output | 1 | Receive buffer holds an unread byte |
| irq_o | output | 1 | Interrupt after an acknowledged byte |
| upd_addr_o | output | 1 | 10-bit header matched; load the low address half |
| start_flag_o | output | 1 | Last bus condition seen was a start |
| stop_flag_o | output | 1 | Last bus condition seen was a stop |

## Verification
A corrupted bit counter or phase register shows up on SDA within the same byte. The acknowledge then arrives one clock late or early, or lands on a byte that should be ignored. The bench samples SDA in the middle of every 9th clock high phase, so such a fault appears at the first byte it affects. A wrong match decision, or a lost transition from the header to the second address byte, shows one byte later. It appears as a missing acknowledge, a stale `rx_byte_o` or an update-address flag in the wrong state. The bench checks each of these right after the acknowledge clock.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

    parameter int BYTE_W = 8;
    localparam int CNT_W = $clog2(BYTE_W + 2);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR2,
        PH_DATA
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        phase_e             nxt;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  shift;
        logic [BYTE_W-1:0]  rx;
        logic               bf;
        logic               irq;
        logic               ua;
        logic               s_flag;
        logic               p_flag;
        logic               ack_drv;
        logic               ack_pend;
    } rx_state_t;

endpackage

// File: rtl/i2c_bus_edges.sv
module i2c_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d      = scl_i;
        sda_d      = sda_i;
        scl_rise_o = scl_i && !scl_q;
        scl_fall_o = !scl_i && scl_q;
        start_o    = scl_i && scl_q && sda_q && !sda_i;
        stop_o     = scl_i && scl_q && !sda_q && sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int ADDR_W = 10
) (
    input  logic [7:0]        byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    output logic              gc_hit_o,
    output logic              short_hit_o,
    output logic              hdr_hit_o,
    output logic              low_hit_o
);
    localparam logic [4:0] HDR_TAG = 5'b11110;
    localparam int         HI_TOP  = ADDR_W - 1;
    localparam int         HI_BOT  = ADDR_W - 2;

    always_comb begin
        gc_hit_o    = gc_en_i && (byte_i == 8'h00);
        short_hit_o = (byte_i[7:1] == own_addr_i[6:0]);
        hdr_hit_o   = (byte_i[7:3] == HDR_TAG)
                   && (byte_i[2:1] == own_addr_i[HI_TOP:HI_BOT])
                   && !byte_i[0];
        low_hit_o   = (byte_i == own_addr_i[7:0]);
    end
endmodule

// File: rtl/i2c_slave_addr_rx.sv
module i2c_slave_addr_rx
    import i2c_addr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ten_bit_i,
    input  logic              gc_en_i,
    input  logic              addr_wr_i,
    input  logic              buf_rd_i,
    input  logic              irq_clr_i,
    output logic              sda_low_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              buf_full_o,
    output logic              irq_o,
    output logic              upd_addr_o,
    output logic              start_flag_o,
    output logic              stop_flag_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(BYTE_W + 1);

    rx_state_t q, d;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic gc_hit, short_hit, hdr_hit, low_hit;
    logic [BYTE_W-1:0] byte_w;

    i2c_bus_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    assign byte_w = {q.shift[BYTE_W-2:0], sda_i};

    i2c_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .byte_i      (byte_w),
        .own_addr_i  (own_addr_i),
        .gc_en_i     (gc_en_i),
        .gc_hit_o    (gc_hit),
        .short_hit_o (short_hit),
        .hdr_hit_o   (hdr_hit),
        .low_hit_o   (low_hit)
    );

    always_comb begin
        logic accept;
        d      = q;
        accept = 1'b0;

        if (addr_wr_i) d.ua  = 1'b0;
        if (buf_rd_i)  d.bf  = 1'b0;
        if (irq_clr_i) d.irq = 1'b0;

        if (start_det) begin
            d.phase    = PH_ADDR;
            d.cnt      = '0;
            d.ack_drv  = 1'b0;
            d.ack_pend = 1'b0;
            d.s_flag   = 1'b1;
            d.p_flag   = 1'b0;
        end else if (stop_det) begin
            d.phase    = PH_IDLE;
            d.cnt      = '0;
            d.ack_drv  = 1'b0;
            d.ack_pend = 1'b0;
            d.s_flag   = 1'b0;
            d.p_flag   = 1'b1;
        end else if (q.phase != PH_IDLE) begin
            if (scl_rise && q.cnt < ACK_END) begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt < ACK_SLOT) d.shift = byte_w;
                if (q.cnt == LAST_BIT) begin
                    unique case (q.phase)
                        PH_ADDR: begin
                            if (gc_hit) begin
                                accept = 1'b1;
                                d.nxt  = PH_DATA;
                            end else if (ten_bit_i && hdr_hit) begin
                                accept = 1'b1;
                                d.nxt  = PH_ADDR2;
                                d.ua   = 1'b1;
                            end else if (!ten_bit_i && short_hit) begin
                                accept = 1'b1;
                                d.nxt  = PH_DATA;
                            end
                        end
                        PH_ADDR2: begin
                            if (low_hit) begin
                                accept = 1'b1;
                                d.nxt  = PH_DATA;
                            end
                        end
                        PH_DATA: begin
                            if (!d.bf) begin
                                accept = 1'b1;
                                d.nxt  = PH_DATA;
                            end
                        end
                        default: accept = 1'b0;
                    endcase
                    if (accept) begin
                        d.rx       = byte_w;
                        d.bf       = 1'b1;
                        d.ack_pend = 1'b1;
                    end else begin
                        d.nxt      = PH_IDLE;
                        d.ack_pend = 1'b0;
                    end
                end
            end
            if (scl_fall) begin
                if (q.cnt == ACK_SLOT) begin
                    d.ack_drv = q.ack_pend;
                end else if (q.cnt == ACK_END) begin
                    d.ack_drv  = 1'b0;
                    if (q.ack_pend) d.irq = 1'b1;
                    d.phase    = q.nxt;
                    d.cnt      = '0;
                    d.ack_pend = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, nxt: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_low_o    = q.ack_drv;
    assign rx_byte_o    = q.rx;
    assign buf_full_o   = q.bf;
    assign irq_o        = q.irq;
    assign upd_addr_o   = q.ua;
    assign start_flag_o = q.s_flag;
    assign stop_flag_o  = q.p_flag;
endmodule

// File: rtl/i2c_slave_addr_rx_chk.sv
module i2c_slave_addr_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic ten_bit_i,
    input logic sda_low_o,
    input logic buf_full_o,
    input logic irq_o,
    input logic upd_addr_o,
    input logic start_flag_o,
    input logic stop_flag_o
);
    // R2: start and stop status never both set
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_flag_o && stop_flag_o));

    // R2: after a stop the slave drives nothing
    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag_o |-> !sda_low_o);

    // R5: buffer-full rises on a rising SCL edge (SCL high that cycle)
    a_r5_bf_on_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full_o) |-> $past(scl_i));

    // R6: interrupt rises after SCL has gone low
    a_r6_irq_on_scl_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !$past(scl_i));

    // R7: update-address only in 10-bit mode
    a_r7_ua_tenbit_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_addr_o) |-> $past(ten_bit_i));

    // R11: acknowledge drive changes only while SCL is low
    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low_o) |-> !$past(scl_i));
endmodule

bind i2c_slave_addr_rx i2c_slave_addr_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .ten_bit_i    (ten_bit_i),
    .sda_low_o    (sda_low_o),
    .buf_full_o   (buf_full_o),
    .irq_o        (irq_o),
    .upd_addr_o   (upd_addr_o),
    .start_flag_o (start_flag_o),
    .stop_flag_o  (stop_flag_o)
);

// File: tb/i2c_slave_addr_rx_test.sv
module i2c_slave_addr_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       bus_sda;
    logic [9:0] own_addr = 10'h02A;
    logic       ten_bit = 1'b0;
    logic       gc_en = 1'b0;
    logic       addr_wr = 1'b0;
    logic       buf_rd = 1'b0;
    logic       irq_clr = 1'b0;

    logic       sda_low;
    logic [7:0] rx_byte;
    logic       buf_full, irq, upd_addr, s_flag, p_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_sda = m_sda & ~sda_low;

    i2c_slave_addr_rx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (bus_sda),
        .own_addr_i   (own_addr),
        .ten_bit_i    (ten_bit),
        .gc_en_i      (gc_en),
        .addr_wr_i    (addr_wr),
        .buf_rd_i     (buf_rd),
        .irq_clr_i    (irq_clr),
        .sda_low_o    (sda_low),
        .rx_byte_o    (rx_byte),
        .buf_full_o   (buf_full),
        .irq_o        (irq),
        .upd_addr_o   (upd_addr),
        .start_flag_o (s_flag),
        .stop_flag_o  (p_flag)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic bus_start;
        if (!m_scl) begin
            m_sda = 1'b1; wait_clk(Q);
            m_scl = 1'b1; wait_clk(Q);
        end
        m_sda = 1'b0; wait_clk(Q);
        m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wait_clk(Q);
        m_scl = 1'b1; wait_clk(Q);
        m_sda = 1'b1; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic bf8,
                             output logic irq_pre, output logic irq_post);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_clk(Q);
            m_scl = 1'b1; wait_clk(2*Q);
            m_scl = 1'b0;
        end
        wait_clk(Q);
        bf8   = buf_full;
        m_sda = 1'b1; wait_clk(Q);
        m_scl = 1'b1; wait_clk(Q);
        ack     = !bus_sda;
        irq_pre = irq;
        wait_clk(Q);
        m_scl = 1'b0; wait_clk(Q);
        irq_post = irq;
    endtask

    task automatic clear_flags;
        buf_rd = 1'b1; irq_clr = 1'b1; addr_wr = 1'b1;
        wait_clk(1);
        buf_rd = 1'b0; irq_clr = 1'b0; addr_wr = 1'b0;
        wait_clk(1);
    endtask

    task automatic t_reset;
        check(sda_low, 0, "R1 sda_low");
        check(buf_full, 0, "R1 buf_full");
        check(irq, 0, "R1 irq");
        check(upd_addr, 0, "R1 upd_addr");
        check({s_flag, p_flag}, 0, "R1 start/stop flags");
        check(rx_byte, 8'h00, "R1 rx_byte");
    endtask

    task automatic t_short_match;
        logic a, b8, ip, iq;
        ten_bit = 0; gc_en = 0; own_addr = 10'h02A;
        bus_start;
        check({s_flag, p_flag}, 2'b10, "R2 start flag");
        send_byte(8'h54, a, b8, ip, iq);
        check(a, 1, "R3 own address ack");
        check(b8, 1, "R5 buf_full before ack clock");
        check(rx_byte, 8'h54, "R5 rx_byte address");
        check(ip, 0, "R6 irq not before 9th fall");
        check(iq, 1, "R6 irq after 9th fall");
        wait_clk(3);
        check(irq, 1, "R6 irq held");
        clear_flags;
        send_byte(8'hC3, a, b8, ip, iq);
        check(a, 1, "R10 data ack");
        check(rx_byte, 8'hC3, "R10 data buffered");
        send_byte(8'h11, a, b8, ip, iq);
        check(a, 0, "R10 nack when full");
        check(rx_byte, 8'hC3, "R10 rx unchanged when full");
        buf_rd = 1; wait_clk(1); buf_rd = 0; wait_clk(1);
        check(buf_full, 0, "R10 buf_rd clears");
        bus_stop;
        check({s_flag, p_flag}, 2'b01, "R2 stop flag");
        clear_flags;
    endtask

    task automatic t_short_miss;
        logic a, b8, ip, iq;
        bus_start;
        send_byte(8'h56, a, b8, ip, iq);
        check(a, 0, "R3 wrong address nack");
        check({buf_full, iq}, 0, "R3 no flags on miss");
        send_byte(8'h54, a, b8, ip, iq);
        check(a, 0, "R3 ignored until next start");
        bus_stop;
    endtask

    task automatic t_gc;
        logic a, b8, ip, iq;
        gc_en = 0;
        bus_start;
        send_byte(8'h00, a, b8, ip, iq);
        check(a, 0, "R4 gc disabled nack");
        bus_stop;
        gc_en = 1;
        rx_byte_prime: begin
            bus_start;
            send_byte(8'h54, a, b8, ip, iq);
            clear_flags;
            bus_start;
        end
        send_byte(8'h00, a, b8, ip, iq);
        check(a, 1, "R4 gc enabled ack");
        check(rx_byte, 8'h00, "R4 gc byte buffered");
        bus_stop;
        clear_flags;
        gc_en = 0;
    endtask

    task automatic t_stop_abort;
        logic a, b8, ip, iq;
        bus_start;
        send_byte(8'h54, a, b8, ip, iq);
        clear_flags;
        bus_stop;
        m_scl = 1'b0; wait_clk(Q);
        send_byte(8'h77, a, b8, ip, iq);
        check(a, 0, "R2 no ack after stop");
        check({buf_full, irq}, 0, "R2 no flags after stop");
        m_scl = 1'b1; wait_clk(Q);
        check(p_flag, 1, "R2 stop flag kept");
    endtask

    task automatic t_ten_bit;
        logic a, b8, ip, iq;
        ten_bit = 1; own_addr = 10'h2A5;
        bus_start;
        send_byte(8'hF4, a, b8, ip, iq);
        check(a, 1, "R7 header ack");
        check(upd_addr, 1, "R7 upd_addr set");
        addr_wr = 1; wait_clk(1); addr_wr = 0; wait_clk(1);
        check(upd_addr, 0, "R7 addr_wr clears");
        clear_flags;
        send_byte(8'hA5, a, b8, ip, iq);
        check(a, 1, "R8 low half ack");
        check(upd_addr, 0, "R8 no second upd_addr");
        clear_flags;
        send_byte(8'h3C, a, b8, ip, iq);
        check(a, 1, "R8 data after 10-bit address");
        check(rx_byte, 8'h3C, "R8 data buffered");
        clear_flags;
        bus_start;
        check(s_flag, 1, "R2 repeated start flag");
        send_byte(8'hF4, a, b8, ip, iq);
        check(a, 1, "R7 header after repeated start");
        clear_flags;
        send_byte(8'hA6, a, b8, ip, iq);
        check(a, 0, "R8 wrong low half nack");
        bus_stop;
        bus_start;
        send_byte(8'hF5, a, b8, ip, iq);
        check(a, 0, "R7 header with bit0=1 nack");
        bus_start;
        send_byte(8'hF6, a, b8, ip, iq);
        check(a, 0, "R7 wrong high bits nack");
        check(upd_addr, 0, "R7 no upd_addr on bad header");
        bus_stop;
        clear_flags;
    endtask

    task automatic t_ten_bit_gc;
        logic a, b8, ip, iq;
        ten_bit = 1; gc_en = 1;
        bus_start;
        send_byte(8'h00, a, b8, ip, iq);
        check(a, 1, "R9 10-bit gc ack");
        check(upd_addr, 0, "R9 gc leaves upd_addr clear");
        clear_flags;
        send_byte(8'h99, a, b8, ip, iq);
        check(a, 1, "R9 data right after gc");
        check(rx_byte, 8'h99, "R9 data buffered");
        check(upd_addr, 0, "R9 upd_addr still clear");
        bus_stop;
        clear_flags;
    endtask

    initial begin
        wait_clk(3);
        t_reset;
        rst_n = 1'b1;
        wait_clk(3);
        t_reset;
        t_short_match;
        t_short_miss;
        t_gc;
        t_stop_abort;
        t_ten_bit;
        t_ten_bit_gc;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule